// File: doc/BRIEF.md
# CPU Exception Entry Controller

This block performs the entry step of exception handling for a small 32-bit processor core. Each cycle it looks at the causes being raised together with those left waiting from earlier cycles. It chooses one, saves the interrupted program counter, updates the interrupt-enable bits and produces the address of the handler. The pipeline then fetches from that address.

Causes fall into two classes. The ordinary class covers bus errors on instruction fetch or data access, divide-by-zero, the external interrupt and the system call. The debug class covers breakpoints and watchpoints. An ordinary entry saves the PC in the exception-return register and copies the global enable into the exception shadow bit. A debug entry saves the PC in the breakpoint-return register and copies the global enable into the breakpoint shadow bit. Either kind clears the global enable. Handlers are spaced 32 bytes apart above a base register. Debug causes always use the debug base. Ordinary causes use the normal base unless the remap bit is set.

A small write port loads the two base registers, the remap bit and the enable bits.

Top module: `exc_entry`

## Requirements
- R1: After reset, pc_o, ea_o, ba_o, cause_o, ie_o, eie_o, bie_o, redirect_o, err_o, both base registers and the remap bit are all zero.
- R2: Ordinary causes are 2 (instruction bus error), 4 (data bus error), 5 (divide-by-zero), 6 (interrupt) and 7 (system call). On an ordinary entry, ea_o takes cur_pc_i and eie_o takes the previous ie_o. ie_o becomes 0, and ba_o and bie_o keep their values.
- R3: Debug causes are 1 (breakpoint) and 3 (watchpoint). On a debug entry, ba_o takes cur_pc_i and bie_o takes the previous ie_o. ie_o becomes 0, and ea_o and eie_o keep their values.
- R4: The handler address on pc_o is the selected base with bits 7:5 replaced by the cause number and bits 4:0 zero.
- R5: Debug causes always use the debug base, whatever the remap bit holds.
- R6: Ordinary causes use the normal base when the remap bit is 0 and the debug base when it is 1.
- R7: Bit n of req_i raises cause n. When several causes are present in one cycle, the lowest number is entered. The others are held pending and entered one per cycle, in increasing order.
- R8: A request on bit 0 (an undefined cause) sets err_o for one cycle. It changes no PC, return-register or enable state, and it is not held pending.
- R9: A write to either base register stores zeros in bits 7:0 of that register, whatever the write data holds.
- R10: wr_sel_i selects the write target: 0 is the normal base, 1 is the debug base, 2 is the remap bit (wr_data_i bit 0), and 3 is the enable bits (bit 0 ie, bit 1 eie, bit 2 bie). When an entry and an enable write fall in the same cycle, the entry sets ie_o and the shadow bit it updates, using the enable value held before that cycle.
- R11: Outputs change at the clock edge on which the cause is taken. redirect_o is high for exactly that one cycle, with cause_o naming the cause. pc_o holds its value in every cycle without an entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 8 | One request bit per cause number |
| cur_pc_i | input | 32 | PC of the instruction being interrupted |
| wr_en_i | input | 1 | Write strobe for the write port |
| wr_sel_i | input | 2 | Write target select |
| wr_data_i | input | 32 | Write data |
| redirect_o | output | 1 | One-cycle pulse: pc_o holds a new handler address |
| cause_o | output | 3 | Cause number of the latest entry |
| pc_o | output | 32 | Handler address of the latest entry |
| ea_o | output | 32 | Saved return address for ordinary exceptions |
| ba_o | output | 32 | Saved return address for debug exceptions |
| ie_o | output | 1 | Global interrupt enable |
| eie_o | output | 1 | Enable shadow for ordinary exceptions |
| bie_o | output | 1 | Enable shadow for debug exceptions |
| err_o | output | 1 | One-cycle pulse on an undefined cause request |

## Verification
A corrupted pending set shows up at the ports in the cycle after the stray or missing bit. redirect_o pulses with an unexpected cause_o, or it stays low when an entry was owed. A wrong class decode or base select appears in the same cycle as the entry: either the wrong return register changes, or pc_o carries the wrong base or a displaced cause field. Enable-bit errors surface immediately on eie_o, bie_o or ie_o. The bench therefore checks every visible field in the entry cycle and again one cycle later.

// File: rtl/exc_entry.sv
module exc_entry #(
  parameter int AW     = 32,
  parameter int NCAUSE = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCAUSE-1:0] req_i,
  input  logic [AW-1:0]     cur_pc_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [AW-1:0]     wr_data_i,
  output logic              redirect_o,
  output logic [$clog2(NCAUSE)-1:0] cause_o,
  output logic [AW-1:0]     pc_o,
  output logic [AW-1:0]     ea_o,
  output logic [AW-1:0]     ba_o,
  output logic              ie_o,
  output logic              eie_o,
  output logic              bie_o,
  output logic              err_o
);
  localparam int CW  = $clog2(NCAUSE);
  localparam int SH  = 5;
  localparam int LOW = CW + SH;

  logic [NCAUSE-1:0] pend_q, cand, grant;
  logic [CW-1:0]     sel;
  logic              hit, dbg;
  logic [AW-1:0]     nbase_q, dbase_q, base, vec;
  logic              remap_q;

  assign cand = pend_q | {req_i[NCAUSE-1:1], 1'b0};

  always_comb begin
    hit = 1'b0;
    sel = '0;
    for (int i = NCAUSE - 1; i >= 1; i--) begin
      if (cand[i]) begin
        hit = 1'b1;
        sel = CW'(i);
      end
    end
  end

  assign grant = hit ? (NCAUSE'(1) << sel) : '0;
  assign dbg   = (sel == CW'(1)) || (sel == CW'(3));
  assign base  = (dbg || remap_q) ? dbase_q : nbase_q;
  assign vec   = {base[AW-1:LOW], sel, {SH{1'b0}}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q     <= '0;
      nbase_q    <= '0;
      dbase_q    <= '0;
      remap_q    <= 1'b0;
      redirect_o <= 1'b0;
      cause_o    <= '0;
      pc_o       <= '0;
      ea_o       <= '0;
      ba_o       <= '0;
      ie_o       <= 1'b0;
      eie_o      <= 1'b0;
      bie_o      <= 1'b0;
      err_o      <= 1'b0;
    end else begin
      redirect_o <= hit;
      err_o      <= req_i[0];
      pend_q     <= cand & ~grant;
      if (wr_en_i) begin
        case (wr_sel_i)
          2'd0: nbase_q <= {wr_data_i[AW-1:LOW], {LOW{1'b0}}};
          2'd1: dbase_q <= {wr_data_i[AW-1:LOW], {LOW{1'b0}}};
          2'd2: remap_q <= wr_data_i[0];
          default: begin
            ie_o  <= wr_data_i[0];
            eie_o <= wr_data_i[1];
            bie_o <= wr_data_i[2];
          end
        endcase
      end
      if (hit) begin
        cause_o <= sel;
        pc_o    <= vec;
        ie_o    <= 1'b0;
        if (dbg) begin
          ba_o  <= cur_pc_i;
          bie_o <= ie_o;
        end else begin
          ea_o  <= cur_pc_i;
          eie_o <= ie_o;
        end
      end
    end
  end
endmodule

module exc_entry_chk #(
  parameter int AW = 32,
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          redirect_o,
  input logic [CW-1:0] cause_o,
  input logic [AW-1:0] pc_o,
  input logic [AW-1:0] ea_o,
  input logic [AW-1:0] ba_o,
  input logic          ie_o,
  input logic          eie_o,
  input logic          bie_o,
  input logic          err_o
);
  logic is_dbg;
  assign is_dbg = (cause_o == CW'(1)) || (cause_o == CW'(3));

  p_ie_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |-> !ie_o);
  p_eie_copy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect_o && !is_dbg) |-> (eie_o == $past(ie_o) && $stable(ba_o)));
  p_bie_copy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect_o && is_dbg) |-> (bie_o == $past(ie_o) && $stable(ea_o)));
  p_vec_field_r4: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |-> (pc_o[CW+4:5] == cause_o && pc_o[4:0] == 5'd0));
  p_pc_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !redirect_o |-> $stable(pc_o));
  p_err_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o && !redirect_o) |-> ($stable(ea_o) && $stable(ba_o) && $stable(pc_o)));
  p_no_zero_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |-> (cause_o != '0));
endmodule

bind exc_entry exc_entry_chk #(.AW(AW), .CW($clog2(NCAUSE))) u_chk (
  .clk(clk), .rst_n(rst_n), .redirect_o(redirect_o), .cause_o(cause_o),
  .pc_o(pc_o), .ea_o(ea_o), .ba_o(ba_o), .ie_o(ie_o), .eie_o(eie_o),
  .bie_o(bie_o), .err_o(err_o)
);

// File: tb/exc_entry_tb.sv
module exc_entry_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [7:0]  req_i = '0;
  logic [31:0] cur_pc_i = '0;
  logic        wr_en_i = 0;
  logic [1:0]  wr_sel_i = '0;
  logic [31:0] wr_data_i = '0;
  logic        redirect_o, ie_o, eie_o, bie_o, err_o;
  logic [2:0]  cause_o;
  logic [31:0] pc_o, ea_o, ba_o;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  exc_entry u_dut (.*);

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      failures++;
      $display("FAIL watchdog: act=%0d exp<=5000 cycles", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] s, logic [31:0] d);
    @(negedge clk);
    wr_en_i = 1; wr_sel_i = s; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 0;
  endtask

  task automatic raise(logic [7:0] m, logic [31:0] pc);
    @(negedge clk);
    req_i = m; cur_pc_i = pc;
    @(negedge clk);
    req_i = '0;
  endtask

  task automatic t_reset;
    chk("R1 pc", pc_o, 0);
    chk("R1 ea/ba", {ea_o | ba_o}, 0);
    chk("R1 flags", {redirect_o, err_o, ie_o, eie_o, bie_o, cause_o}, 0);
  endtask

  task automatic t_ordinary;
    wr(0, 32'h1000_0000);
    wr(1, 32'h2000_0000);
    wr(3, 32'h1);
    raise(8'h40, 32'h0000_1234);
    chk("R4 R6 pc cause6", pc_o, 32'h1000_00C0);
    chk("R2 ea", ea_o, 32'h1234);
    chk("R2 ba untouched", ba_o, 0);
    chk("R2 ie/eie/bie", {ie_o, eie_o, bie_o}, 3'b010);
    chk("R11 redirect cause", {redirect_o, cause_o}, {1'b1, 3'd6});
    @(negedge clk);
    chk("R11 pulse ends, pc holds", {redirect_o, pc_o}, {1'b0, 32'h1000_00C0});
  endtask

  task automatic t_debug;
    wr(3, 32'h1);
    raise(8'h08, 32'h0000_5678);
    chk("R5 pc cause3", pc_o, 32'h2000_0060);
    chk("R3 ba", ba_o, 32'h5678);
    chk("R3 ea untouched", ea_o, 32'h1234);
    chk("R3 ie/eie/bie", {ie_o, eie_o, bie_o}, 3'b001);
  endtask

  task automatic t_ie_zero;
    wr(3, 32'h2);
    raise(8'h20, 32'h0000_0AAA);
    chk("R2 eie takes ie=0", {ie_o, eie_o, bie_o}, 3'b000);
    chk("R4 pc cause5", pc_o, 32'h1000_00A0);
  endtask

  task automatic t_remap;
    wr(2, 32'h1);
    raise(8'h04, 32'h0000_0100);
    chk("R6 remap ordinary to debug base", pc_o, 32'h2000_0040);
    raise(8'h02, 32'h0000_0104);
    chk("R5 debug with remap", pc_o, 32'h2000_0020);
    wr(2, 32'h0);
    raise(8'h80, 32'h0000_0108);
    chk("R6 remap off cause7", pc_o, 32'h1000_00E0);
  endtask

  task automatic t_base_mask;
    wr(0, 32'h3000_00FF);
    raise(8'h10, 32'h0000_0200);
    chk("R9 low bits dropped", pc_o, 32'h3000_0080);
  endtask

  task automatic t_priority;
    raise(8'hA4, 32'h0000_0300);
    chk("R7 first cause2", {redirect_o, cause_o}, {1'b1, 3'd2});
    @(negedge clk);
    chk("R7 second cause5", {redirect_o, cause_o}, {1'b1, 3'd5});
    @(negedge clk);
    chk("R7 third cause7", {redirect_o, cause_o, pc_o}, {1'b1, 3'd7, 32'h3000_00E0});
    @(negedge clk);
    chk("R7 drained", {31'd0, redirect_o}, 0);
  endtask

  task automatic t_err;
    logic [31:0] p, e, b;
    p = pc_o; e = ea_o; b = ba_o;
    raise(8'h01, 32'h0000_0999);
    chk("R8 err pulse no redirect", {err_o, redirect_o}, 2'b10);
    chk("R8 pc unchanged", pc_o, p);
    chk("R8 ea/ba unchanged", {ea_o ^ e} | {ba_o ^ b}, 0);
    @(negedge clk);
    chk("R8 err cleared, nothing pending", {err_o, redirect_o}, 2'b00);
  endtask

  task automatic t_write_race;
    wr(3, 32'h0);
    @(negedge clk);
    wr_en_i = 1; wr_sel_i = 3; wr_data_i = 32'h1;
    req_i = 8'h40; cur_pc_i = 32'h0000_0777;
    @(negedge clk);
    wr_en_i = 0; req_i = '0;
    chk("R10 entry wins, eie from old ie", {ie_o, eie_o}, 2'b00);
    chk("R10 ea", ea_o, 32'h777);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_ordinary();
    t_debug();
    t_ie_zero();
    t_remap();
    t_base_mask();
    t_priority();
    t_err();
    t_write_race();
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule